// File: doc/BRIEF.md
# Multi-Supply Reset Supervisor with Power-Up Skew Window

This block turns the supply-good flags of four monitored rails, four over-current flags and an active-low manual reset request into two active-low reset outputs. The system reset asserts while any of these conditions is present. It stays asserted for a programmable number of extra clock cycles after the last condition clears. All monitor inputs and the manual reset pass through a two-flop synchronizer before the block uses them.

The delayed reset serves a downstream supply sequencer. While the rails are ramping, it stays released and gives them a programmable skew window. The window opens on the first rail that is detected. If the window closes before all four rails are good, the delayed reset asserts. Once all rails are good, the delayed reset follows the system reset, including its stretch. When every rail drops out, the block returns to its power-down state, so the next ramp gets a fresh window. Timer lengths are cycle counts on input ports.

The power-tracking state machine has four states:
- `PWR_OFF`: no rail is present.
- `PWR_RAMP`: the window is running.
- `PWR_RUN`: all rails have been good.
- `PWR_SKEWFAIL`: the window expired while at least one rail was still missing.

Its transitions are:
- OFF→RUN: all rails appear at once.
- OFF→RAMP: some but not all rails appear, and the window count is nonzero.
- OFF→SKEWFAIL: the same, but the window count is zero.
- RAMP→RUN: all rails become good.
- RAMP→SKEWFAIL: the count runs out.
- RAMP→OFF, RUN→OFF and SKEWFAIL→OFF: every rail drops out.
- SKEWFAIL→RUN: all rails become good.

Top module: `supply_reset_sequencer`

## Requirements
- R1: A low supply-good flag (any of four) drives `sys_rst_n_o` low 3 clock edges after the input changes: 2 synchronizer flops plus the timer register.
- R2: Any high over-current flag asserts `sys_rst_n_o` (low) with the same 3-edge latency.
- R3: A low `man_rst_n_i` asserts `sys_rst_n_o` with the same 3-edge latency.
- R4: After the last condition of R1–R3 is removed, `sys_rst_n_o` returns high exactly 3+S edges later, where S is `stretch_len_i`. S=0 gives no stretch.
- R5: During and right after `rst_n` is low, with no rail present, `sys_rst_n_o` is low and `dly_rst_n_o` is high.
- R6: In power-down and during the skew window, `dly_rst_n_o` stays high, whatever the over-current flags and the manual reset do.
- R7: When the first rail appears and not all four are good, `dly_rst_n_o` goes low 3+W edges after that input change, where W is `skew_len_i`. With W=0 this happens after 3 edges.
- R8: If all four rails are good by the last window cycle, the block enters normal operation and the skew failure is never signalled. When all-good and expiry fall in the same cycle, all-good wins. With S=0, `dly_rst_n_o` then never goes low.
- R9: In normal operation `dly_rst_n_o` equals `sys_rst_n_o`. After a skew failure, it stays low until all rails are good, and then follows `sys_rst_n_o`.
- R10: When all four rails drop out, the block returns to power-down: `dly_rst_n_o` is high again, and the next rail to appear opens a new window.
- R11: All monitor inputs and the manual reset are sampled through two flops, so no output reacts sooner than 3 edges after an input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| supply_ok_i | input | 4 | Per-rail supply-good flags, high = above threshold |
| overcur_i | input | 4 | Per-rail over-current flags, high = fault |
| man_rst_n_i | input | 1 | Manual reset request, active low |
| stretch_len_i | input | 16 | Extra cycles the system reset holds after faults clear |
| skew_len_i | input | 16 | Power-up skew window length in cycles |
| sys_rst_n_o | output | 1 | Stretched system reset, active low |
| dly_rst_n_o | output | 1 | Delayed (skew-checked) reset, active low |

## Verification
Two events can fall in the same cycle: the skew window reaching its last cycle, and the synchronized all-rails-good condition. The bench opens the window with W=6. It raises the last rail exactly 6 edges after the first, so both events land on edge 9. It sets S=0 so that the system reset's stretch cannot hide the outcome. The delayed reset must stay high on every edge. A second run raises the last rail one edge later, and the delayed reset must go low at edge 9 to show the expiry path.

// File: rtl/srs_pkg.sv
package srs_pkg;
    typedef enum logic [1:0] {
        PWR_OFF,
        PWR_RAMP,
        PWR_RUN,
        PWR_SKEWFAIL
    } pwr_state_e;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/srs_stretch.sv
module srs_stretch #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fault_i,
    input  logic [CW-1:0] len_i,
    output logic          act_o
);
    logic [CW-1:0] cnt_q;
    logic          act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= 1'b1;
        end else if (fault_i) begin
            cnt_q <= len_i;
            act_q <= 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
            act_q <= 1'b1;
        end else begin
            act_q <= 1'b0;
        end
    end

    assign act_o = act_q;

    // R1, R2, R3: any active condition holds the reset on the next edge
    assert_fault_asserts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> act_o);

    // R4: a nonzero stretch keeps the reset past the first clear cycle
    assert_stretch_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fault_i) && !fault_i && len_i != '0 && $stable(len_i)) |=> act_o);
endmodule

// File: rtl/srs_pwr_fsm.sv
module srs_pwr_fsm
    import srs_pkg::*;
#(
    parameter int NS = 4,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] ok_i,
    input  logic [CW-1:0] skew_i,
    input  logic          main_act_i,
    output pwr_state_e    state_o,
    output logic          dly_act_o
);
    pwr_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          all_ok, any_ok;

    assign all_ok = &ok_i;
    assign any_ok = |ok_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_OFF: begin
                if (all_ok)      state_d = PWR_RUN;
                else if (any_ok) state_d = (skew_i == '0) ? PWR_SKEWFAIL : PWR_RAMP;
            end
            PWR_RAMP: begin
                if (all_ok)              state_d = PWR_RUN;
                else if (!any_ok)        state_d = PWR_OFF;
                else if (cnt_q == '0)    state_d = PWR_SKEWFAIL;
            end
            PWR_RUN: begin
                if (!any_ok)     state_d = PWR_OFF;
            end
            PWR_SKEWFAIL: begin
                if (all_ok)       state_d = PWR_RUN;
                else if (!any_ok) state_d = PWR_OFF;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == PWR_OFF && state_d == PWR_RAMP) begin
            cnt_q <= skew_i - CW'(1);
        end else if (state_q == PWR_RAMP && cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    always_comb begin
        unique case (state_q)
            PWR_OFF, PWR_RAMP: dly_act_o = 1'b0;
            PWR_RUN:           dly_act_o = main_act_i;
            PWR_SKEWFAIL:      dly_act_o = 1'b1;
        endcase
    end

    assign state_o = state_q;

    // R7: skew failure entered only from an exhausted window or a zero window
    assert_skewfail_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == PWR_SKEWFAIL) |->
            (($past(state_q) == PWR_RAMP && $past(cnt_q) == '0) ||
             ($past(state_q) == PWR_OFF && $past(skew_i) == '0)));

    // R8: normal operation is entered only with every rail good
    assert_run_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == PWR_RUN) |-> $past(all_ok));

    // R10: power-down is re-entered only after every rail is gone
    assert_off_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == PWR_OFF) |-> $past(!any_ok));

    // R6: the window counter never runs outside the ramp state
    assert_cnt_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PWR_RAMP && $past(state_q) != PWR_OFF) |=> $stable(cnt_q) || state_q == PWR_RAMP);
endmodule

// File: rtl/supply_reset_sequencer.sv
module supply_reset_sequencer
    import srs_pkg::*;
#(
    parameter int NS = 4,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] supply_ok_i,
    input  logic [NS-1:0] overcur_i,
    input  logic          man_rst_n_i,
    input  logic [CW-1:0] stretch_len_i,
    input  logic [CW-1:0] skew_len_i,
    output logic          sys_rst_n_o,
    output logic          dly_rst_n_o
);
    localparam int SW = 2 * NS + 1;
    localparam logic [SW-1:0] SYNC_RST = {{(2*NS){1'b0}}, 1'b1};

    logic [SW-1:0] raw_vec, syn_vec;
    logic [NS-1:0] s_ok, s_oc;
    logic          s_mr_n;
    logic          fault;
    logic          main_act, dly_act;
    pwr_state_e    pwr_state;

    assign raw_vec = {supply_ok_i, overcur_i, man_rst_n_i};

    srs_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_vec),
        .q_o   (syn_vec)
    );

    assign s_ok   = syn_vec[SW-1 -: NS];
    assign s_oc   = syn_vec[NS -: NS];
    assign s_mr_n = syn_vec[0];

    assign fault = ~(&s_ok) | (|s_oc) | ~s_mr_n;

    srs_stretch #(.CW(CW)) u_stretch (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault_i (fault),
        .len_i   (stretch_len_i),
        .act_o   (main_act)
    );

    srs_pwr_fsm #(.NS(NS), .CW(CW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ok_i       (s_ok),
        .skew_i     (skew_len_i),
        .main_act_i (main_act),
        .state_o    (pwr_state),
        .dly_act_o  (dly_act)
    );

    assign sys_rst_n_o = ~main_act;
    assign dly_rst_n_o = ~dly_act;

    // R9: in normal operation the delayed reset can only be low when the main one is
    assert_dly_implies_sys_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PWR_RUN && !dly_rst_n_o) |-> !sys_rst_n_o);

    // R6: the delayed reset is released while powered down or ramping
    assert_dly_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PWR_OFF || pwr_state == PWR_RAMP) |-> dly_rst_n_o);
endmodule

// File: tb/supply_reset_sequencer_bench.sv
module supply_reset_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  supply_ok;
    logic [3:0]  overcur;
    logic        man_rst_n;
    logic [15:0] stretch_len;
    logic [15:0] skew_len;
    logic        sys_rst_n, dly_rst_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #10ns clk = ~clk;

    supply_reset_sequencer u_supply_reset_sequencer (
        .clk           (clk),
        .rst_n         (rst_n),
        .supply_ok_i   (supply_ok),
        .overcur_i     (overcur),
        .man_rst_n_i   (man_rst_n),
        .stretch_len_i (stretch_len),
        .skew_len_i    (skew_len),
        .sys_rst_n_o   (sys_rst_n),
        .dly_rst_n_o   (dly_rst_n)
    );

    // fields: [10:7] supply_ok, [6:3] overcur, [2] man_rst_n, [1] exp sys, [0] exp dly
    localparam logic [10:0] VEC [9] = '{
        11'b1111_0000_1_1_1,  // R1 all clear
        11'b1111_0001_1_0_0,  // R2 over-current rail 0
        11'b1111_0000_0_0_0,  // R3 manual reset
        11'b1111_0000_1_1_1,
        11'b1110_0000_1_0_0,  // R1 one rail low
        11'b1111_1000_1_0_0,  // R2 over-current rail 3
        11'b1111_0000_1_1_1,
        11'b1111_0010_0_0_0,  // R3 manual plus over-current
        11'b1111_0000_1_1_1
    };

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [15:0] s, input logic [15:0] w);
        @(negedge clk);
        rst_n = 1'b0;
        supply_ok = 4'b0000; overcur = 4'b0000; man_rst_n = 1'b1;
        stretch_len = s; skew_len = w;
        edges(3);
        check("R5", sys_rst_n, 1'b0, "sys during reset");
        check("R5", dly_rst_n, 1'b1, "dly during reset");
        rst_n = 1'b1;
        edges(4);
    endtask

    initial begin
        #(20ns * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        supply_ok = '0; overcur = '0; man_rst_n = 1'b1;
        stretch_len = '0; skew_len = '0;

        // R5 reset state
        do_reset(16'd3, 16'd20);
        check("R5", sys_rst_n, 1'b0, "sys after reset, no rails");
        check("R5", dly_rst_n, 1'b1, "dly after reset, no rails");

        // vector table, steady state in normal operation
        supply_ok = 4'b1111;
        edges(12);
        for (int i = 0; i < 9; i++) begin
            supply_ok = VEC[i][10:7];
            overcur   = VEC[i][6:3];
            man_rst_n = VEC[i][2];
            edges(10);
            check("R1/R2/R3 sys", sys_rst_n, VEC[i][1], $sformatf("vector %0d", i));
            check("R9 dly", dly_rst_n, VEC[i][0], $sformatf("vector %0d", i));
        end

        // R4 stretch with S=0 and S=5; R1 latency
        foreach (VEC[k]) if (k < 2) begin
            stretch_len = (k == 0) ? 16'd0 : 16'd5;
            edges(2);
            man_rst_n = 1'b0;
            edges(2);
            check("R11", sys_rst_n, 1'b1, "no reaction before 3 edges");
            edges(1);
            check("R1", sys_rst_n, 1'b0, "assert at 3 edges");
            edges(3);
            man_rst_n = 1'b1;
            edges(2 + int'(stretch_len));
            check("R4", sys_rst_n, 1'b0, $sformatf("still held S=%0d", stretch_len));
            check("R9", dly_rst_n, 1'b0, "dly follows during stretch");
            edges(1);
            check("R4", sys_rst_n, 1'b1, $sformatf("released S=%0d", stretch_len));
            check("R9", dly_rst_n, 1'b1, "dly follows release");
        end

        // R7 window expiry, W=6
        do_reset(16'd0, 16'd6);
        supply_ok = 4'b0011;
        edges(8);
        check("R7", dly_rst_n, 1'b1, "window still open at 2+W");
        edges(1);
        check("R7", dly_rst_n, 1'b0, "skew failure at 3+W");
        supply_ok = 4'b1111;
        edges(2);
        check("R9", dly_rst_n, 1'b0, "held after skew failure");
        edges(3);
        check("R9", dly_rst_n, 1'b1, "recovered once all good");
        check("R9", sys_rst_n, 1'b1, "sys released");

        // R10 all rails gone, fresh window
        supply_ok = 4'b0000;
        edges(6);
        check("R10", dly_rst_n, 1'b1, "power-down releases dly");
        check("R10", sys_rst_n, 1'b0, "sys held in power-down");
        supply_ok = 4'b0100;
        edges(8);
        check("R10", dly_rst_n, 1'b1, "new window open");
        edges(1);
        check("R10", dly_rst_n, 1'b0, "new window expired");

        // R7 zero window
        do_reset(16'd0, 16'd0);
        supply_ok = 4'b0001;
        edges(2);
        check("R7", dly_rst_n, 1'b1, "W=0 before 3 edges");
        edges(1);
        check("R7", dly_rst_n, 1'b0, "W=0 immediate failure");

        // R6 faults ignored by dly while ramping
        do_reset(16'd0, 16'd20);
        supply_ok = 4'b0001; overcur = 4'b0001; man_rst_n = 1'b0;
        edges(10);
        check("R6", dly_rst_n, 1'b1, "dly quiet in window");
        check("R6", sys_rst_n, 1'b0, "sys asserted in window");
        supply_ok = 4'b0000;
        edges(6);
        check("R6", dly_rst_n, 1'b1, "dly quiet in power-down with manual low");
        overcur = '0; man_rst_n = 1'b1;

        // R8 coincidence: all-good and expiry on the same edge
        do_reset(16'd0, 16'd6);
        supply_ok = 4'b0001;
        edges(6);
        supply_ok = 4'b1111;
        begin
            int lows = 0;
            for (int e = 0; e < 12; e++) begin
                edges(1);
                if (dly_rst_n !== 1'b1) lows++;
            end
            check("R8", logic'(lows == 0), 1'b1, "dly never low when all-good meets expiry");
        end
        check("R8", sys_rst_n, 1'b1, "sys released after coincidence");

        // R7 one edge later: expiry wins
        do_reset(16'd0, 16'd6);
        supply_ok = 4'b0001;
        edges(7);
        supply_ok = 4'b1111;
        edges(2);
        check("R7", dly_rst_n, 1'b0, "expiry one edge before all-good");
        edges(5);
        check("R9", dly_rst_n, 1'b1, "normal after late all-good");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule